// File: doc/BRIEF.md
# Shadowed Window Configuration Register Bank

This block holds the per-window configuration for a small set of overlay windows in a display scan-out path. Each window has an enable bit, a top-left and an inclusive bottom-right position, a buffer start address, a buffer end address and a stride word. Software writes land in an active copy of every register. The scan-out logic sees only a second, shadow copy, which is exposed on dedicated output ports.

The active copy moves into the shadow copy on a transfer. A transfer happens on a frame-boundary strobe, or one cycle after software sets a standalone-update bit. A per-window protect bit in a global shadow-control register holds back the transfer for that window. Software sets the bit before a multi-register edit and clears it afterwards, so scan-out never sees a half-written window.

A window that was protected during a transfer keeps its old shadow contents. It picks up its active values at the next transfer after the protect bit is cleared. Register reads always return the active copy.

Top module: `shadow_win_bank`

## Requirements
- R1: After synchronous reset, every active register, every shadow output, the protect mask and the update bit are zero.
- R2: A register address is {page, index[2:0]}. Pages 0 to NUM_WIN-1 select a window. Within a window page the indices are:
  - index 0: control, enable in bit 0.
  - index 1: top-left position, X in bits 23:12 and Y in bits 11:0.
  - index 2: inclusive bottom-right position, same packing as index 1.
  - index 3: start address, 32 bits.
  - index 4: end address, 32 bits.
  - index 5: stride, offset size in bits 27:14 and page width in bits 13:0.
  A write stores the defined bits, and a read returns them with every undefined bit as zero.
- R3: A read issued with rd_en_i is presented on rd_data_o in the following cycle and holds while rd_en_i is low. Reads return the active copy, never the shadow copy.
- R4: Writes to active registers leave all shadow outputs unchanged until a transfer occurs.
- R5: On a clock edge where frame_i is high, every unprotected window copies all of its active fields into its shadow. The shadow outputs show the new values after that edge.
- R6: Page NUM_WIN, index 0 is the protect mask, with bit w for window w. A protected window's shadow does not change on a frame strobe or on a standalone update. It takes its current active values on the first transfer after its bit is cleared.
- R7: Page NUM_WIN, index 1, bit 0 is the standalone update. Writing 1 sets it, and on the next edge it performs a transfer for every unprotected window and clears itself. A read issued in the cycle right after the write returns 1, and a later read returns 0. Writing 0 starts no transfer.
- R8: Writes to undefined addresses change no state, and reads of undefined addresses return zero. The undefined addresses are window-page indices 6 and 7, and global-page indices 2 to 7.
- R9: If an active register is written on the same edge as a transfer, the shadow takes the previous active value. The new value reaches the shadow at the next transfer.
- R10: Window w's shadow fields occupy slice w of each output vector: bit w of shd_en_o, [w*24 +: 24] of the position outputs, [w*32 +: 32] of the address outputs and [w*28 +: 28] of shd_stride_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | PAGE_W+3 | Write address {page, index} |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | PAGE_W+3 | Read address {page, index} |
| rd_data_o | output | 32 | Read data, one cycle after rd_en_i |
| frame_i | input | 1 | Frame-boundary strobe |
| shd_en_o | output | NUM_WIN | Shadow window enables |
| shd_tl_o | output | NUM_WIN*24 | Shadow top-left positions |
| shd_br_o | output | NUM_WIN*24 | Shadow bottom-right positions |
| shd_base_o | output | NUM_WIN*32 | Shadow start addresses |
| shd_last_o | output | NUM_WIN*32 | Shadow end addresses |
| shd_stride_o | output | NUM_WIN*28 | Shadow stride words |

## Verification
The bench builds the default configuration: three windows with a two-bit page field, so the global page sits at page 3 and the address space is 32 words. This size allows every one of the eight protect masks to be swept twice, once under frame strobes and once under standalone updates. Each pass rewrites all 18 window registers and compares them with a bench model, both through readback and on the shadow outputs. Directed steps cover the remaining cases: the undefined addresses, a write of zero to the update bit, and an active write that collides with a frame strobe.

// File: rtl/swb_pkg.sv
package swb_pkg;

  localparam int DATA_W   = 32;
  localparam int COORD_W  = 12;
  localparam int POS_W    = 2 * COORD_W;
  localparam int SPAN_W   = 14;
  localparam int STRIDE_W = 2 * SPAN_W;
  localparam int IDX_W    = 3;
  localparam int NUM_IDX  = 6;

  typedef enum logic [IDX_W-1:0] {
    IDX_CTRL   = 3'd0,
    IDX_TL     = 3'd1,
    IDX_BR     = 3'd2,
    IDX_BASE   = 3'd3,
    IDX_LAST   = 3'd4,
    IDX_STRIDE = 3'd5
  } win_idx_e;

  localparam logic [IDX_W-1:0] GIDX_PROT = 3'd0;
  localparam logic [IDX_W-1:0] GIDX_UPD  = 3'd1;

  typedef struct packed {
    logic                en;
    logic [POS_W-1:0]    tl;
    logic [POS_W-1:0]    br;
    logic [DATA_W-1:0]   base;
    logic [DATA_W-1:0]   last;
    logic [STRIDE_W-1:0] stride;
  } win_cfg_t;

endpackage

// File: rtl/swb_decode.sv
module swb_decode
  import swb_pkg::*;
#(
  parameter int NUM_WIN = 3,
  parameter int PAGE_W  = 2
) (
  input  logic                              wr_en_i,
  input  logic [PAGE_W+IDX_W-1:0]           wr_addr_i,
  output logic [NUM_WIN-1:0][NUM_IDX-1:0]   win_we_o,
  output logic                              prot_we_o,
  output logic                              upd_we_o
);

  logic [PAGE_W-1:0] page;
  logic [IDX_W-1:0]  idx;

  assign page = wr_addr_i[PAGE_W+IDX_W-1:IDX_W];
  assign idx  = wr_addr_i[IDX_W-1:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    for (genvar r = 0; r < NUM_IDX; r++) begin : g_reg
      assign win_we_o[w][r] = wr_en_i && (page == PAGE_W'(w)) && (idx == IDX_W'(r));
    end
  end

  assign prot_we_o = wr_en_i && (page == PAGE_W'(NUM_WIN)) && (idx == GIDX_PROT);
  assign upd_we_o  = wr_en_i && (page == PAGE_W'(NUM_WIN)) && (idx == GIDX_UPD);

endmodule

// File: rtl/swb_window.sv
module swb_window
  import swb_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IDX-1:0] we_i,
  input  logic [DATA_W-1:0]  wd_i,
  input  logic               commit_i,
  output win_cfg_t           act_o,
  output win_cfg_t           shd_o
);

  win_cfg_t act_q;
  win_cfg_t shd_q;

  // Active copy: software-visible, written field by field.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
    end else begin
      if (we_i[IDX_CTRL])   act_q.en     <= wd_i[0];
      if (we_i[IDX_TL])     act_q.tl     <= wd_i[POS_W-1:0];
      if (we_i[IDX_BR])     act_q.br     <= wd_i[POS_W-1:0];
      if (we_i[IDX_BASE])   act_q.base   <= wd_i;
      if (we_i[IDX_LAST])   act_q.last   <= wd_i;
      if (we_i[IDX_STRIDE]) act_q.stride <= wd_i[STRIDE_W-1:0];
    end
  end

  // Shadow copy: scan-out view, loaded as a whole on commit.
  always_ff @(posedge clk) begin
    if (rst) begin
      shd_q <= '0;
    end else if (commit_i) begin
      shd_q <= act_q;
    end
  end

  assign act_o = act_q;
  assign shd_o = shd_q;

endmodule

// File: rtl/swb_readback.sv
module swb_readback
  import swb_pkg::*;
#(
  parameter int NUM_WIN = 3,
  parameter int PAGE_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd_en_i,
  input  logic [PAGE_W+IDX_W-1:0]   rd_addr_i,
  input  win_cfg_t [NUM_WIN-1:0]    act_i,
  input  logic [NUM_WIN-1:0]        prot_i,
  input  logic                      upd_i,
  output logic [DATA_W-1:0]         rd_data_o
);

  logic [PAGE_W-1:0] page;
  logic [IDX_W-1:0]  idx;
  win_cfg_t          cfg;
  logic              hit;
  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] rd_q;

  assign page = rd_addr_i[PAGE_W+IDX_W-1:IDX_W];
  assign idx  = rd_addr_i[IDX_W-1:0];

  always_comb begin
    cfg = '0;
    hit = 1'b0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (page == PAGE_W'(w)) begin
        cfg = act_i[w];
        hit = 1'b1;
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (hit) begin
      case (idx)
        IDX_CTRL:   rd_next = {{(DATA_W-1){1'b0}}, cfg.en};
        IDX_TL:     rd_next = {{(DATA_W-POS_W){1'b0}}, cfg.tl};
        IDX_BR:     rd_next = {{(DATA_W-POS_W){1'b0}}, cfg.br};
        IDX_BASE:   rd_next = cfg.base;
        IDX_LAST:   rd_next = cfg.last;
        IDX_STRIDE: rd_next = {{(DATA_W-STRIDE_W){1'b0}}, cfg.stride};
        default:    rd_next = '0;
      endcase
    end else if (page == PAGE_W'(NUM_WIN)) begin
      case (idx)
        GIDX_PROT: rd_next = {{(DATA_W-NUM_WIN){1'b0}}, prot_i};
        GIDX_UPD:  rd_next = {{(DATA_W-1){1'b0}}, upd_i};
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_en_i) begin
      rd_q <= rd_next;
    end
  end

  assign rd_data_o = rd_q;

endmodule

// File: rtl/shadow_win_bank.sv
module shadow_win_bank
  import swb_pkg::*;
#(
  parameter int NUM_WIN = 3,
  parameter int PAGE_W  = $clog2(NUM_WIN + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en_i,
  input  logic [PAGE_W+2:0]             wr_addr_i,
  input  logic [31:0]                   wr_data_i,
  input  logic                          rd_en_i,
  input  logic [PAGE_W+2:0]             rd_addr_i,
  output logic [31:0]                   rd_data_o,
  input  logic                          frame_i,
  output logic [NUM_WIN-1:0]            shd_en_o,
  output logic [NUM_WIN*24-1:0]         shd_tl_o,
  output logic [NUM_WIN*24-1:0]         shd_br_o,
  output logic [NUM_WIN*32-1:0]         shd_base_o,
  output logic [NUM_WIN*32-1:0]         shd_last_o,
  output logic [NUM_WIN*28-1:0]         shd_stride_o
);

  logic [NUM_WIN-1:0][NUM_IDX-1:0] win_we;
  logic                            prot_we;
  logic                            upd_we;
  logic [NUM_WIN-1:0]              prot_q;
  logic                            upd_q;
  logic                            xfer;
  logic [NUM_WIN-1:0]              commit;
  win_cfg_t [NUM_WIN-1:0]          act;
  win_cfg_t [NUM_WIN-1:0]          shd;

  swb_decode #(
    .NUM_WIN (NUM_WIN),
    .PAGE_W  (PAGE_W)
  ) u_decode (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .win_we_o  (win_we),
    .prot_we_o (prot_we),
    .upd_we_o  (upd_we)
  );

  // Global shadow control: protect mask and one-shot update request.
  always_ff @(posedge clk) begin
    if (rst) begin
      prot_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      if (prot_we) prot_q <= wr_data_i[NUM_WIN-1:0];
      upd_q <= upd_we && wr_data_i[0];
    end
  end

  assign xfer   = frame_i || upd_q;
  assign commit = {NUM_WIN{xfer}} & ~prot_q;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    swb_window u_win (
      .clk      (clk),
      .rst      (rst),
      .we_i     (win_we[w]),
      .wd_i     (wr_data_i),
      .commit_i (commit[w]),
      .act_o    (act[w]),
      .shd_o    (shd[w])
    );

    assign shd_en_o[w]               = shd[w].en;
    assign shd_tl_o[w*POS_W +: POS_W] = shd[w].tl;
    assign shd_br_o[w*POS_W +: POS_W] = shd[w].br;
    assign shd_base_o[w*DATA_W +: DATA_W] = shd[w].base;
    assign shd_last_o[w*DATA_W +: DATA_W] = shd[w].last;
    assign shd_stride_o[w*STRIDE_W +: STRIDE_W] = shd[w].stride;
  end

  swb_readback #(
    .NUM_WIN (NUM_WIN),
    .PAGE_W  (PAGE_W)
  ) u_readback (
    .clk       (clk),
    .rst       (rst),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .act_i     (act),
    .prot_i    (prot_q),
    .upd_i     (upd_q),
    .rd_data_o (rd_data_o)
  );

endmodule

// File: rtl/swb_chk.sv
module swb_chk
  import swb_pkg::*;
#(
  parameter int NUM_WIN = 3,
  parameter int PAGE_W  = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    frame_i,
  input logic                    upd_q,
  input logic                    upd_we,
  input logic [31:0]             wr_data_i,
  input logic [NUM_WIN-1:0]      prot_q,
  input win_cfg_t [NUM_WIN-1:0]  act,
  input win_cfg_t [NUM_WIN-1:0]  shd,
  input logic                    rd_en_i,
  input logic [PAGE_W+2:0]       rd_addr_i,
  input logic [31:0]             rd_data_o
);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_w
    AST_PROT_FREEZE: assert property (@(posedge clk) disable iff (rst)
      prot_q[w] |=> $stable(shd[w])); // R6

    AST_XFER_COPY: assert property (@(posedge clk) disable iff (rst)
      ((frame_i || upd_q) && !prot_q[w]) |=> (shd[w] == $past(act[w]))); // R5
  end

  AST_NO_XFER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(frame_i || upd_q) |=> $stable(shd)); // R4

  AST_UPD_ONESHOT: assert property (@(posedge clk) disable iff (rst)
    (upd_q && !(upd_we && wr_data_i[0])) |=> !upd_q); // R7

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rd_data_o)); // R3

  AST_CTRL_RD_NARROW: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && rd_addr_i[2:0] == 3'd0 && rd_addr_i[PAGE_W+2:3] < PAGE_W'(NUM_WIN))
      |=> (rd_data_o[31:1] == '0)); // R2

endmodule

bind shadow_win_bank swb_chk #(
  .NUM_WIN (NUM_WIN),
  .PAGE_W  (PAGE_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .frame_i   (frame_i),
  .upd_q     (upd_q),
  .upd_we    (upd_we),
  .wr_data_i (wr_data_i),
  .prot_q    (prot_q),
  .act       (act),
  .shd       (shd),
  .rd_en_i   (rd_en_i),
  .rd_addr_i (rd_addr_i),
  .rd_data_o (rd_data_o)
);

// File: tb/shadow_win_bank_test.sv
module shadow_win_bank_test;

  localparam int NW = 3;
  localparam int PW = 2;
  localparam int AW = PW + 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en_i = 1'b0;
  logic [AW-1:0]   wr_addr_i = '0;
  logic [31:0]     wr_data_i = '0;
  logic            rd_en_i = 1'b0;
  logic [AW-1:0]   rd_addr_i = '0;
  logic [31:0]     rd_data_o;
  logic            frame_i = 1'b0;
  logic [NW-1:0]       shd_en_o;
  logic [NW*24-1:0]    shd_tl_o;
  logic [NW*24-1:0]    shd_br_o;
  logic [NW*32-1:0]    shd_base_o;
  logic [NW*32-1:0]    shd_last_o;
  logic [NW*28-1:0]    shd_stride_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] exp_act [NW][6];
  logic [31:0] exp_shd [NW][6];

  always #2.5 clk = ~clk;

  shadow_win_bank #(.NUM_WIN(NW), .PAGE_W(PW)) uut (
    .clk, .rst, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_en_i, .rd_addr_i,
    .rd_data_o, .frame_i, .shd_en_o, .shd_tl_o, .shd_br_o, .shd_base_o,
    .shd_last_o, .shd_stride_o
  );

  function automatic logic [31:0] fmask(int idx);
    case (idx)
      0: return 32'h0000_0001;
      1, 2: return 32'h00FF_FFFF;
      3, 4: return 32'hFFFF_FFFF;
      5: return 32'h0FFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] pat(int seed, int w, int r);
    logic [31:0] v;
    v = 32'h9E37_79B9 * 32'(seed * 18 + w * 6 + r + 1);
    return v ^ {v[15:0], v[31:16]};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int page, int idx, logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = AW'((page << 3) | idx); wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    if (page < NW && idx < 6) exp_act[page][idx] = d & fmask(idx);
  endtask

  task automatic rd(int page, int idx, output logic [31:0] d);
    rd_en_i = 1'b1; rd_addr_i = AW'((page << 3) | idx);
    @(negedge clk);
    rd_en_i = 1'b0;
    d = rd_data_o;
  endtask

  task automatic model_xfer(logic [NW-1:0] prot);
    for (int w = 0; w < NW; w++)
      if (!prot[w])
        for (int r = 0; r < 6; r++) exp_shd[w][r] = exp_act[w][r];
  endtask

  task automatic frame_pulse();
    frame_i = 1'b1;
    @(negedge clk);
    frame_i = 1'b0;
  endtask

  task automatic chk_shadows(string req);
    for (int w = 0; w < NW; w++) begin
      chk(shd_en_o[w] == exp_shd[w][0][0], req, 32'(shd_en_o[w]), exp_shd[w][0]);
      chk(shd_tl_o[w*24 +: 24] == exp_shd[w][1][23:0], req, 32'(shd_tl_o[w*24 +: 24]), exp_shd[w][1]);
      chk(shd_br_o[w*24 +: 24] == exp_shd[w][2][23:0], req, 32'(shd_br_o[w*24 +: 24]), exp_shd[w][2]);
      chk(shd_base_o[w*32 +: 32] == exp_shd[w][3], req, shd_base_o[w*32 +: 32], exp_shd[w][3]);
      chk(shd_last_o[w*32 +: 32] == exp_shd[w][4], req, shd_last_o[w*32 +: 32], exp_shd[w][4]);
      chk(shd_stride_o[w*28 +: 28] == exp_shd[w][5][27:0], req, 32'(shd_stride_o[w*28 +: 28]), exp_shd[w][5]);
    end
  endtask

  task automatic chk_readback(string req);
    logic [31:0] d;
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < 6; r++) begin
        rd(w, r, d);
        chk(d == exp_act[w][r], req, d, exp_act[w][r]);
      end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < 6; r++) begin exp_act[w][r] = '0; exp_shd[w][r] = '0; end

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state on outputs and readback
    chk_shadows("R1");
    chk_readback("R1");
    rd(NW, 0, d); chk(d == 0, "R1 protect", d, 0);
    rd(NW, 1, d); chk(d == 0, "R1 update", d, 0);

    // R2 R3 R4: write all fields, read back masked active, shadows idle
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < 6; r++) wr(w, r, pat(99, w, r) | 32'hF000_0000);
    chk_readback("R2_R3");
    chk_shadows("R4");

    // R5 R10: frame strobe copies everything
    frame_pulse(); model_xfer('0);
    chk_shadows("R5_R10");

    // R6 R7 sweep: every protect mask under both trigger kinds
    for (int trig = 0; trig < 2; trig++)
      for (int m = 0; m < 8; m++) begin
        wr(NW, 0, 32'(m));
        for (int w = 0; w < NW; w++)
          for (int r = 0; r < 6; r++) wr(w, r, pat(trig * 8 + m, w, r));
        chk_shadows("R4 sweep");
        rd(NW, 0, d); chk(d == 32'(m), "R6 protect readback", d, 32'(m));
        if (trig == 0) begin
          frame_pulse();
        end else begin
          wr(NW, 1, 32'h1);
          rd(NW, 1, d); chk(d == 1, "R7 update set", d, 1);
          rd(NW, 1, d); chk(d == 0, "R7 update clear", d, 0);
        end
        model_xfer(NW'(m));
        chk_shadows(trig == 0 ? "R6 frame" : "R6 update");
        chk_readback("R3 active after transfer");
      end

    // R6: clearing protect alone moves nothing; the next transfer picks up
    wr(NW, 0, 32'h0);
    chk_shadows("R6 clear no move");
    frame_pulse(); model_xfer('0);
    chk_shadows("R6 pickup");

    // R7: writing zero to the update bit starts nothing
    wr(1, 3, 32'h1234_5678);
    wr(NW, 1, 32'h0);
    rd(NW, 1, d); chk(d == 0, "R7 zero write", d, 0);
    chk_shadows("R7 zero write");

    // R8: undefined addresses
    for (int r = 6; r < 8; r++) begin
      for (int w = 0; w < NW; w++) begin
        wr(w, r, 32'hFFFF_FFFF);
        rd(w, r, d); chk(d == 0, "R8 window gap", d, 0);
      end
    end
    for (int r = 2; r < 8; r++) begin
      wr(NW, r, 32'hFFFF_FFFF);
      rd(NW, r, d); chk(d == 0, "R8 global gap", d, 0);
    end
    rd(NW, 0, d); chk(d == 0, "R8 protect untouched", d, 0);
    chk_readback("R8 windows untouched");
    chk_shadows("R8 no transfer");

    // R9: active write on the same edge as a frame strobe
    frame_pulse(); model_xfer('0);
    frame_i = 1'b1; wr(2, 4, 32'hCAFE_F00D); frame_i = 1'b0;
    chk(shd_last_o[2*32 +: 32] == exp_shd[2][4], "R9 old value",
        shd_last_o[2*32 +: 32], exp_shd[2][4]);
    frame_pulse(); model_xfer('0);
    chk(shd_last_o[2*32 +: 32] == 32'hCAFE_F00D, "R9 new value",
        shd_last_o[2*32 +: 32], 32'hCAFE_F00D);
    chk_shadows("R9");

    finish_run();
  end

endmodule